// File: doc/BRIEF.md
# Five-Operation March Test Sequencer

This block drives a memory array through a short march test that is meant to run alongside per-column bitline sensors. After a start pulse it writes all ones into every row, then walks the rows again in ascending order. On each row it applies write 0, read 0, write 1 and read 1. Every cell therefore sees exactly five operations. Every bit of a write word carries the same value, so every cell in a row receives the same stimulus. This is what lets the neighbour-comparison logic spot a cell that behaves differently from the cells beside it.

During the second pass, each operation opens an evaluation window for the external comparison logic. The sequencer holds the window open and issues no further memory operation until the comparator returns its done pulse. That pulse carries a flag that reports a parametric mismatch. Each read is also checked against the expected all-zeros or all-ones word. A mismatch sets a sticky logic-fail flag, and the sequence keeps running so that parametric results are still gathered. The row of the first failure of either kind is held until the next start. A one-cycle done pulse ends the run.

Top module: `march_seq`

## Requirements
- R1: After `start_i` is accepted, the first ROWS_P memory operations are writes of the all-ones word to rows 0, 1, ..., ROWS_P-1 in that order. `win_o` is low during these writes.
- R2: Next, for each row in ascending order, the block issues exactly four operations in the order write 0, read 0, write 1, read 1. Write 0 and write 1 put the all-zeros and all-ones words on `wdata_o`. A run holds 5*ROWS_P operations in total.
- R3: Whenever `we_o` is high, every bit of `wdata_o` is equal. `we_o` and `re_o` are never high together.
- R4: Each second-pass operation is issued with `win_o` high. In the cycles after it, `win_o` stays high and no operation is issued until `cmp_done_i` is seen high at a clock edge. The next operation, or `done_o`, follows in the very next cycle.
- R5: The memory returns read data on `rd_data_i` one cycle after `re_o`. If that word differs from the expected word, `logic_fail_o` is set and stays set, and the run continues to completion.
- R6: When `cmp_done_i` and `cmp_flag_i` are high together while the block waits on a window, `param_fail_o` is set and stays set.
- R7: At the first failure of either kind, `fail_valid_o` goes high and `fail_row_o` captures the row being tested. Later failures do not change `fail_row_o`.
- R8: `done_o` is high for exactly one cycle, directly after the comparator done of the final read 1. `busy_o` is high from the cycle after the start until the done cycle, and low in the cycle after it.
- R9: `start_i` has no effect while `busy_o` is high. A start that is accepted in idle clears `logic_fail_o`, `param_fail_o`, `fail_valid_o` and `fail_row_o`.
- R10: After reset, `busy_o`, `done_o`, `we_o`, `re_o`, `win_o` and all fail outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start a test run (used only when idle) |
| cmp_done_i | input | 1 | Comparator finished evaluating the open window |
| cmp_flag_i | input | 1 | Comparator mismatch, valid with cmp_done_i |
| rd_data_i | input | WIDTH_P | Read word, valid one cycle after re_o |
| addr_o | output | clog2(ROWS_P) | Row address |
| we_o | output | 1 | Write enable |
| re_o | output | 1 | Read enable |
| wdata_o | output | WIDTH_P | Write word (all bits equal) |
| win_o | output | 1 | Sensor evaluation window |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | One-cycle end-of-run pulse |
| logic_fail_o | output | 1 | Sticky read-data mismatch |
| param_fail_o | output | 1 | Sticky comparator mismatch |
| fail_valid_o | output | 1 | A failure row has been captured |
| fail_row_o | output | clog2(ROWS_P) | Row of the first failure |

## Verification
A wrong row counter or operation index appears at once as an out-of-order address, enable or data value on the very next memory operation. The bench compares every operation against the position where it is expected. A control state that fails to wait, or waits too long, shows up in the first cycle after a comparator done as a missing or extra operation. Wrong capture of the failure state shows at the fail outputs at the end of the run. Runs with one fault, with two faults in either order, and with the comparator answering at different latencies separate first-capture errors from sticky-flag errors.

// File: rtl/march_pkg.sv
package march_pkg;
  typedef enum logic [2:0] {ST_IDLE, ST_INIT, ST_OP, ST_WAIT, ST_FIN} st_e;
  // op[1] is the data value of the operation
  typedef enum logic [1:0] {OP_W0 = 2'd0, OP_R0 = 2'd1, OP_W1 = 2'd2, OP_R1 = 2'd3} op_e;
endpackage

// File: rtl/march_ctrl.sv
module march_ctrl
  import march_pkg::*;
#(
  parameter int ROWS_P = 16,
  parameter int AW_P   = 4
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            start_i,
  input  logic            cmp_done_i,
  output logic [AW_P-1:0] row_o,
  output logic            we_o,
  output logic            re_o,
  output logic            bit_o,
  output logic            win_o,
  output logic            busy_o,
  output logic            done_o,
  output logic            start_acc_o,
  output logic            accept_o
);
  localparam logic [AW_P-1:0] LAST = AW_P'(ROWS_P - 1);

  st_e             st_q;
  op_e             op_q;
  logic [AW_P-1:0] row_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_IDLE;
      op_q  <= OP_W0;
      row_q <= '0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (start_i) begin
          st_q  <= ST_INIT;
          row_q <= '0;
        end
        ST_INIT: begin
          if (row_q == LAST) begin
            row_q <= '0;
            op_q  <= OP_W0;
            st_q  <= ST_OP;
          end else begin
            row_q <= row_q + 1'b1;
          end
        end
        ST_OP: st_q <= ST_WAIT;
        ST_WAIT: if (cmp_done_i) begin
          if (op_q == OP_R1) begin
            if (row_q == LAST) begin
              st_q <= ST_FIN;
            end else begin
              row_q <= row_q + 1'b1;
              op_q  <= OP_W0;
              st_q  <= ST_OP;
            end
          end else begin
            op_q <= op_e'(op_q + 2'd1);
            st_q <= ST_OP;
          end
        end
        ST_FIN: st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    row_o       = row_q;
    we_o        = (st_q == ST_INIT) || (st_q == ST_OP && !op_q[0]);
    re_o        = (st_q == ST_OP) && op_q[0];
    bit_o       = (st_q == ST_INIT) ? 1'b1 : op_q[1];
    win_o       = (st_q == ST_OP) || (st_q == ST_WAIT);
    busy_o      = (st_q != ST_IDLE);
    done_o      = (st_q == ST_FIN);
    start_acc_o = (st_q == ST_IDLE) && start_i;
    accept_o    = (st_q == ST_WAIT) && cmp_done_i;
  end

  // R3
  rw_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni) !(we_o && re_o));
  // R4
  win_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_WAIT && !cmp_done_i) |=> (win_o && !we_o && !re_o));
  // R8
  done_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni) done_o |=> !busy_o);
  // R2
  row_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni) row_q <= LAST);
endmodule

// File: rtl/march_rdchk.sv
module march_rdchk #(
  parameter int WIDTH_P = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               re_i,
  input  logic               bit_i,
  input  logic [WIDTH_P-1:0] rd_data_i,
  output logic               err_o
);
  logic pend_q, exp_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b0;
      exp_q  <= 1'b0;
    end else begin
      pend_q <= re_i;
      if (re_i) exp_q <= bit_i;
    end
  end

  assign err_o = pend_q && (rd_data_i != {WIDTH_P{exp_q}});

  // R5
  err_after_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> $past(re_i));
endmodule

// File: rtl/march_fail_log.sv
module march_fail_log #(
  parameter int AW_P = 4
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            clr_i,
  input  logic            lfail_i,
  input  logic            pfail_i,
  input  logic [AW_P-1:0] row_i,
  output logic            logic_fail_o,
  output logic            param_fail_o,
  output logic            valid_o,
  output logic [AW_P-1:0] row_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      logic_fail_o <= 1'b0;
      param_fail_o <= 1'b0;
      valid_o      <= 1'b0;
      row_o        <= '0;
    end else if (clr_i) begin
      logic_fail_o <= 1'b0;
      param_fail_o <= 1'b0;
      valid_o      <= 1'b0;
      row_o        <= '0;
    end else begin
      if (lfail_i) logic_fail_o <= 1'b1;
      if (pfail_i) param_fail_o <= 1'b1;
      if ((lfail_i || pfail_i) && !valid_o) begin
        valid_o <= 1'b1;
        row_o   <= row_i;
      end
    end
  end

  // R7
  first_row_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !clr_i) |=> (valid_o && $stable(row_o)));
  // R5
  lfail_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (logic_fail_o && !clr_i) |=> logic_fail_o);
endmodule

// File: rtl/march_seq.sv
module march_seq #(
  parameter int ROWS_P  = 16,
  parameter int WIDTH_P = 8,
  localparam int AW     = (ROWS_P > 1) ? $clog2(ROWS_P) : 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic               cmp_done_i,
  input  logic               cmp_flag_i,
  input  logic [WIDTH_P-1:0] rd_data_i,
  output logic [AW-1:0]      addr_o,
  output logic               we_o,
  output logic               re_o,
  output logic [WIDTH_P-1:0] wdata_o,
  output logic               win_o,
  output logic               busy_o,
  output logic               done_o,
  output logic               logic_fail_o,
  output logic               param_fail_o,
  output logic               fail_valid_o,
  output logic [AW-1:0]      fail_row_o
);
  logic data_bit, start_acc, accept, rd_err;

  march_ctrl #(.ROWS_P(ROWS_P), .AW_P(AW)) u_ctrl (
    .clk_i, .rst_ni, .start_i, .cmp_done_i,
    .row_o(addr_o), .we_o, .re_o, .bit_o(data_bit), .win_o,
    .busy_o, .done_o, .start_acc_o(start_acc), .accept_o(accept)
  );

  // same value on every bit of the word
  for (genvar g = 0; g < WIDTH_P; g++) begin : g_wd
    assign wdata_o[g] = data_bit;
  end

  march_rdchk #(.WIDTH_P(WIDTH_P)) u_rdchk (
    .clk_i, .rst_ni, .re_i(re_o), .bit_i(data_bit), .rd_data_i, .err_o(rd_err)
  );

  march_fail_log #(.AW_P(AW)) u_log (
    .clk_i, .rst_ni, .clr_i(start_acc), .lfail_i(rd_err),
    .pfail_i(accept && cmp_flag_i), .row_i(addr_o),
    .logic_fail_o, .param_fail_o, .valid_o(fail_valid_o), .row_o(fail_row_o)
  );

  // R3
  wdata_uniform_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_o |-> (wdata_o == '0 || wdata_o == '1));
  // R9
  busy_ignore_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !done_o) |=> busy_o);
endmodule

// File: tb/tb_march_seq.sv
`timescale 1ns/1ps
module tb_march_seq;
  localparam int ROWS = 16;
  localparam int W    = 8;
  localparam int AW   = 4;
  localparam int NOPS = 5 * ROWS;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 1'b0, cmp_done = 1'b0, cmp_flag = 1'b0;
  logic [W-1:0] rd_data = '0;
  logic [AW-1:0] addr, fail_row;
  logic we, re, win, busy, done, lfail, pfail, fvalid;
  logic [W-1:0] wdata;

  always #2.5 clk = ~clk;

  march_seq #(.ROWS_P(ROWS), .WIDTH_P(W)) dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .cmp_done_i(cmp_done),
    .cmp_flag_i(cmp_flag), .rd_data_i(rd_data), .addr_o(addr), .we_o(we),
    .re_o(re), .wdata_o(wdata), .win_o(win), .busy_o(busy), .done_o(done),
    .logic_fail_o(lfail), .param_fail_o(pfail), .fail_valid_o(fvalid),
    .fail_row_o(fail_row)
  );

  int errors = 0, checks = 0, cycles = 0;
  int lat = 2, win_idx = 0, win_cnt = 0, op_idx = 0, done_cnt = 0;
  bit lf_en = 0, pf_en = 0, monitor = 0, prev_win = 0, prev_done = 0;
  int lf_row = 0, pf_row = 0, pf_op = 0;
  logic [W-1:0] mem [ROWS];

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // behavioural memory: registered read, optional bit-0 flip on one row
  always @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    if (re) rd_data <= mem[addr] ^ ((lf_en && int'(addr) == lf_row) ? W'(1) : W'(0));
  end

  always @(negedge clk) begin
    bit given;
    given = cmp_done;
    cycles++;
    if (monitor) begin
      if (we || re) begin
        int row, op, ew, er, eb, ewin;
        if (op_idx < ROWS) begin
          row = op_idx; ew = 1; er = 0; eb = 1; ewin = 0;
        end else begin
          row = (op_idx - ROWS) / 4; op = (op_idx - ROWS) % 4;
          ew = (op % 2 == 0); er = !ew; eb = (op >= 2); ewin = 1;
        end
        if (op_idx >= NOPS) chk(0, "R2 extra op", op_idx, NOPS);
        else if (op_idx < ROWS) begin
          chk(int'(addr) == row && we && win == 0 && wdata == '1, "R1 init write",
              {addr, we, win}, {row[AW-1:0], 1'b1, 1'b0});
        end else begin
          chk(int'(addr) == row && we == ew[0] && re == er[0] && win == ewin[0],
              "R2 op order", {addr, we, re, win}, {row[AW-1:0], ew[0], er[0], ewin[0]});
          if (we) chk(wdata == {W{eb[0]}}, "R3 wdata", wdata, {W{eb[0]}});
        end
        op_idx++;
      end
      if (given) chk(we || re || done, "R4 op after cmp done", {we, re, done}, 1);
      else if (win && prev_win) chk(!we && !re, "R4 hold while waiting", {we, re}, 0);
      if (done) begin
        done_cnt++;
        chk(op_idx == NOPS && busy, "R8 done at end", op_idx, NOPS);
      end
      if (prev_done) chk(!busy && !done, "R8 busy drop", {busy, done}, 0);
    end
    // comparator model
    if (cmp_done) begin
      cmp_done = 1'b0; cmp_flag = 1'b0;
      win_cnt = win ? 1 : 0;
    end else if (win) begin
      win_cnt++;
      if (win_cnt >= lat) begin
        cmp_done = 1'b1;
        cmp_flag = pf_en && (win_idx / 4 == pf_row) && (win_idx % 4 == pf_op);
        win_idx++;
      end
    end else win_cnt = 0;
    prev_win = win; prev_done = done;
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=0", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic run(input int l, input bit le, input int lr, input bit pe, input int pr,
                     input int po, input bit mid_start);
    int t;
    int lidx, pidx, exp_row;
    lat = l; lf_en = le; lf_row = lr; pf_en = pe; pf_row = pr; pf_op = po;
    win_idx = 0; op_idx = 0; done_cnt = 0; monitor = 1;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    chk(busy && !lfail && !pfail && !fvalid, "R9 start clears flags",
        {busy, lfail, pfail, fvalid}, 4'b1000);
    t = 0;
    while (!done && t < 5000) begin
      @(negedge clk); t++;
      if (mid_start && t == 30) start = 1'b1;
      if (mid_start && t == 31) start = 1'b0;
    end
    repeat (3) @(negedge clk);
    chk(done_cnt == 1, "R8 one done pulse", done_cnt, 1);
    chk(op_idx == NOPS, "R2 op total", op_idx, NOPS);
    chk(lfail == le, "R5 logic fail", lfail, le);
    chk(pfail == pe, "R6 param fail", pfail, pe);
    chk(fvalid == (le || pe), "R7 fail valid", fvalid, le || pe);
    lidx = lr * 4 + 1; pidx = pr * 4 + po;
    exp_row = (le && pe) ? ((pidx < lidx) ? pr : lr) : (le ? lr : (pe ? pr : 0));
    chk(int'(fail_row) == exp_row, "R7 first fail row", fail_row, exp_row);
    monitor = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!busy && !done && !we && !re && !win && !lfail && !pfail && !fvalid,
        "R10 reset state", {busy, done, we, re, win, lfail, pfail, fvalid}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    run(2, 0, 0, 0, 0, 0, 1);   // clean, start while busy (R9)
    run(4, 0, 0, 0, 0, 0, 0);   // clean, slower comparator
    run(2, 1, 5, 1, 9, 3, 0);   // logic first (R5, R7)
    run(3, 1, 7, 1, 2, 0, 0);   // parametric first (R6, R7)
    run(2, 0, 0, 1, 15, 3, 0);  // flag on last window
    run(2, 1, 15, 0, 0, 0, 0);  // logic fault on last row
    run(2, 0, 0, 0, 0, 0, 0);   // clean after faults: R9 clear
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule